// File: doc/BRIEF.md
# Pointer-Tracking Memoryless Viterbi Decoder

This core decodes a rate-1/3 convolutional code without a survivor memory. Each accepted trellis step delivers eight branch metrics, one for each possible 3-bit code word. A bank of add-compare-select butterflies updates one path metric per trellis state and produces one decision bit per state. A single state pointer walks forward through the trellis. It starts at the all-zero state at the beginning of every block of L steps and reads only the decisions next to the state it currently names. The bit it picks is both the decoded output and the new least significant bit of the pointer, so decoded bits leave in their natural order two clock edges after the step that produced them.

The transmitter must clear its encoder register every L input bits, so that every block starts in state zero. The data stream itself is continuous, with no tail bits and no pause. The number of states (2^(K-1)), the block length, the metric widths and the three generator polynomials are parameters.

Top module: `mlvd_core`

## Requirements
- R1: While `rst` is high, `out_valid` and `out_first` are 0 and `in_ready` is 0. After reset is released, `in_ready` is 1.
- R2: Every new path metric is the smaller of its two predecessor sums (old metric plus branch metric), saturated at the top of the metric range. The decision bit is 0 when the predecessor whose most significant state bit is 0 wins, and 1 otherwise. Equal sums give decision 0, and the tracker then prefers input bit 0. So a stream in which every branch metric is equal decodes to all zeros.
- R3: After every accepted step the smallest path metric is zero, because the minimum is subtracted from all of them. No path metric ever wraps around.
- R4: On the first step after reset, and on every L-th step after that, the old metrics are replaced by 0 for state 0 and half of the metric range for every other state, and the pointer is taken as state 0. A reset in the middle of a block starts a new block.
- R5: From pointer state P, the two candidate successors are A = {P[M-2:0],0} and B = {P[M-2:0],1}. A successor "names" P when its decision bit equals P[M-1]. If exactly one candidate names P, the decoded bit is the input bit that leads to it. Otherwise the bit is 1 only when B's metric is strictly smaller than A's.
- R6: After each decoded bit the pointer becomes {P[M-2:0], bit}. It is stored as a circular register, with a rotating write position that receives the new bit.
- R7: Each accepted step (`in_valid` and `in_ready` high at a rising edge) produces exactly one output, with `out_valid` high right after the second rising edge that follows it. Idle cycles produce no output, and outputs keep step order.
- R8: `out_first` is high together with `out_valid` exactly for the first decoded bit of each block, that is, on every L-th output counted from reset.
- R9: With noiseless metrics from an encoder that is cleared every L bits, the decoded bits equal the encoded data bits.
- R10: Branch metric c sits at `in_bm[c*BMW +: BMW]`. The code word of a transition from state s with input u is {c2,c1,c0}, where ck is the parity of the K-bit register {s,u} (u in bit 0) ANDed with generator Gk. Each generator must have its bit 0 and bit K-1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A trellis step's branch metrics are present |
| in_ready | output | 1 | Step can be accepted (high outside reset) |
| in_bm | input | 8*BMW | Eight unsigned branch metrics, indexed by code word |
| out_valid | output | 1 | Decoded bit is valid this cycle |
| out_bit | output | 1 | Decoded data bit |
| out_first | output | 1 | Decoded bit is the first of a block |

## Verification
Block boundaries get the most attention. Runs of ones leave the encoder in a non-zero state at the end of a block. A decoder that failed to force its pointer or its metrics back to state zero would emit wrong bits right after the boundary. A reset in the middle of a block would misplace `out_first` and desynchronise the pointer if the step counter were not cleared. Streams with all metrics equal expose a tie rule that leans toward 1 or an inverted decision polarity, both of which show up as ones in the output. Long runs with the largest metric scale would expose a path metric that wraps instead of saturating. Bursts with idle gaps and a single isolated step pin the two-edge latency and the rule of one output per step.

// File: rtl/mlvd_pkg.sv
package mlvd_pkg;

    localparam int NCODE = 3;
    localparam int NBM   = 1 << NCODE;

    typedef struct packed {
        logic valid;
        logic first;
    } step_tag_t;

    // Code word emitted when input u leaves state st (u is register bit 0).
    function automatic logic [NCODE-1:0] branch_code(input int unsigned st,
                                                      input logic u,
                                                      input int unsigned g0,
                                                      input int unsigned g1,
                                                      input int unsigned g2);
        int unsigned r;
        r = (st << 1) | (u ? 32'd1 : 32'd0);
        return {^(r & g2), ^(r & g1), ^(r & g0)};
    endfunction

endpackage

// File: rtl/mlvd_butterfly.sv
module mlvd_butterfly #(
    parameter int BMW = 5,
    parameter int PMW = 8
) (
    input  logic [PMW-1:0] pm_i,
    input  logic [PMW-1:0] pm_j,
    input  logic [BMW-1:0] bm_a,
    input  logic [BMW-1:0] bm_b,
    output logic [PMW-1:0] pm_p,
    output logic [PMW-1:0] pm_q,
    output logic           dec_p,
    output logic           dec_q
);
    // Symmetric code: BM(i,p)=BM(j,q)=bm_a and BM(i,q)=BM(j,p)=bm_b.
    logic [PMW:0] s_ip, s_jp, s_iq, s_jq, sel_p, sel_q;

    always_comb begin
        s_ip  = {1'b0, pm_i} + (PMW+1)'(bm_a);
        s_jp  = {1'b0, pm_j} + (PMW+1)'(bm_b);
        s_iq  = {1'b0, pm_i} + (PMW+1)'(bm_b);
        s_jq  = {1'b0, pm_j} + (PMW+1)'(bm_a);
        dec_p = s_jp < s_ip;
        dec_q = s_jq < s_iq;
        sel_p = dec_p ? s_jp : s_ip;
        sel_q = dec_q ? s_jq : s_iq;
        pm_p  = sel_p[PMW] ? '1 : sel_p[PMW-1:0];
        pm_q  = sel_q[PMW] ? '1 : sel_q[PMW-1:0];
    end

endmodule

// File: rtl/mlvd_acs_bank.sv
module mlvd_acs_bank
    import mlvd_pkg::*;
#(
    parameter int K   = 3,
    parameter int BMW = 5,
    parameter int PMW = 8,
    parameter int L   = 15,
    parameter int G0  = 5,
    parameter int G1  = 7,
    parameter int G2  = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic [NBM*BMW-1:0]           bm_flat,
    output logic [(1<<(K-1))*PMW-1:0]    pm_flat,
    output logic [(1<<(K-1))-1:0]        dec,
    output step_tag_t                    tag
);
    localparam int M  = K - 1;
    localparam int S  = 1 << M;
    localparam int NB = S / 2;
    localparam int CW = $clog2(L);
    localparam logic [PMW-1:0] PM_BIG = {1'b1, {(PMW-1){1'b0}}};

    logic [BMW-1:0] bm      [NBM];
    logic [PMW-1:0] pm_q    [S];
    logic [PMW-1:0] pm_old  [S];
    logic [PMW-1:0] pm_raw  [S];
    logic [PMW-1:0] pm_norm [S];
    logic [PMW-1:0] pm_min;
    logic [S-1:0]   dec_w;
    logic [CW-1:0]  cnt;
    logic           first_now;

    assign first_now = (cnt == '0);

    for (genvar c = 0; c < NBM; c++) begin : g_bm
        assign bm[c] = bm_flat[c*BMW +: BMW];
    end

    always_comb begin
        for (int s = 0; s < S; s++)
            pm_old[s] = first_now ? ((s == 0) ? '0 : PM_BIG) : pm_q[s];
    end

    for (genvar x = 0; x < NB; x++) begin : g_bf
        localparam logic [NCODE-1:0] CA = branch_code(x, 1'b0, G0, G1, G2);
        localparam logic [NCODE-1:0] CB = branch_code(x, 1'b1, G0, G1, G2);
        mlvd_butterfly #(.BMW(BMW), .PMW(PMW)) u_bf (
            .pm_i (pm_old[x]),
            .pm_j (pm_old[x+NB]),
            .bm_a (bm[CA]),
            .bm_b (bm[CB]),
            .pm_p (pm_raw[2*x]),
            .pm_q (pm_raw[2*x+1]),
            .dec_p(dec_w[2*x]),
            .dec_q(dec_w[2*x+1])
        );
    end

    always_comb begin
        pm_min = pm_raw[0];
        for (int s = 1; s < S; s++)
            if (pm_raw[s] < pm_min) pm_min = pm_raw[s];
        for (int s = 0; s < S; s++)
            pm_norm[s] = pm_raw[s] - pm_min;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tag <= '0;
            dec <= '0;
            for (int s = 0; s < S; s++) pm_q[s] <= '0;
        end else begin
            tag.valid <= step;
            tag.first <= step & first_now;
            if (step) begin
                cnt <= (int'(cnt) == L - 1) ? '0 : cnt + 1'b1;
                dec <= dec_w;
                for (int s = 0; s < S; s++) pm_q[s] <= pm_norm[s];
            end
        end
    end

    for (genvar s = 0; s < S; s++) begin : g_pm_out
        assign pm_flat[s*PMW +: PMW] = pm_q[s];
    end

    // Checks
    logic any_zero;
    always_comb begin
        any_zero = 1'b0;
        for (int s = 0; s < S; s++)
            if (pm_q[s] == '0) any_zero = 1'b1;
    end

    p_norm_zero_r3: assert property (@(posedge clk) disable iff (rst)
        tag.valid |-> any_zero);

    p_blk_count_r8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < L);

endmodule

// File: rtl/mlvd_tracker.sv
module mlvd_tracker
    import mlvd_pkg::*;
#(
    parameter int K   = 3,
    parameter int PMW = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  step_tag_t                 tag,
    input  logic [(1<<(K-1))-1:0]     dec,
    input  logic [(1<<(K-1))*PMW-1:0] pm_flat,
    output logic                      out_valid,
    output logic                      out_bit,
    output logic                      out_first
);
    localparam int M  = K - 1;
    localparam int WW = (M > 1) ? $clog2(M) : 1;

    logic [M-1:0]   ptr_raw, ptr_nxt, cur, p_eff, ia, ib;
    logic [WW-1:0]  wpos;
    logic [PMW-1:0] pm_a, pm_b;
    logic           names_a, names_b, u;

    // Logical state: bit 0 is the most recently written bit.
    always_comb begin
        for (int k = 0; k < M; k++) begin
            int t;
            t = int'(wpos) + M - 1 - k;
            if (t >= M) t = t - M;
            cur[k] = ptr_raw[t];
        end
    end

    always_comb begin
        p_eff   = tag.first ? '0 : cur;
        ia      = {p_eff[M-2:0], 1'b0};
        ib      = {p_eff[M-2:0], 1'b1};
        pm_a    = pm_flat[ia*PMW +: PMW];
        pm_b    = pm_flat[ib*PMW +: PMW];
        names_a = (dec[ia] == p_eff[M-1]);
        names_b = (dec[ib] == p_eff[M-1]);
        u       = (names_a ^ names_b) ? names_b : (pm_b < pm_a);
        ptr_nxt = tag.first ? '0 : ptr_raw;
        ptr_nxt[wpos] = u;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_raw   <= '0;
            wpos      <= '0;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_first <= 1'b0;
        end else begin
            out_valid <= tag.valid;
            out_first <= tag.valid & tag.first;
            if (tag.valid) begin
                out_bit <= u;
                ptr_raw <= ptr_nxt;
                wpos    <= (int'(wpos) == M - 1) ? '0 : wpos + 1'b1;
            end
        end
    end

    p_first_valid_r8: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);

    p_block_ptr_r4: assert property (@(posedge clk) disable iff (rst)
        (tag.valid && tag.first) |=> (cur[M-1:1] == '0));

    p_ptr_shift_r6: assert property (@(posedge clk) disable iff (rst)
        (tag.valid && !tag.first) |=> (cur[M-1:1] == $past(cur[M-2:0])));

endmodule

// File: rtl/mlvd_core.sv
module mlvd_core
    import mlvd_pkg::*;
#(
    parameter int K   = 3,
    parameter int BMW = 5,
    parameter int PMW = 8,
    parameter int L   = 5 * K,
    parameter int G0  = 5,
    parameter int G1  = 7,
    parameter int G2  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [NBM*BMW-1:0] in_bm,
    output logic               out_valid,
    output logic               out_bit,
    output logic               out_first
);
    localparam int S = 1 << (K - 1);

    logic [S*PMW-1:0] pm_flat;
    logic [S-1:0]     dec;
    step_tag_t        tag;
    logic             in_fire;

    assign in_ready = ~rst;
    assign in_fire  = in_valid & in_ready;

    mlvd_acs_bank #(
        .K(K), .BMW(BMW), .PMW(PMW), .L(L), .G0(G0), .G1(G1), .G2(G2)
    ) u_acs (
        .clk    (clk),
        .rst    (rst),
        .step   (in_fire),
        .bm_flat(in_bm),
        .pm_flat(pm_flat),
        .dec    (dec),
        .tag    (tag)
    );

    mlvd_tracker #(.K(K), .PMW(PMW)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .tag      (tag),
        .dec      (dec),
        .pm_flat  (pm_flat),
        .out_valid(out_valid),
        .out_bit  (out_bit),
        .out_first(out_first)
    );

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        in_fire |-> ##2 out_valid);

    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !in_fire |-> ##2 !out_valid);

endmodule

// File: tb/mlvd_core_bench.sv
module mlvd_core_bench;
    import mlvd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int K   = 3;
    localparam int BMW = 5;
    localparam int PMW = 8;
    localparam int L   = 15;
    localparam int G0  = 5;
    localparam int G1  = 7;
    localparam int G2  = 7;
    localparam int S   = 1 << (K - 1);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [NBM*BMW-1:0] in_bm = '0;
    logic               out_valid, out_bit, out_first;

    int checks = 0;
    int errors = 0;
    bit    exp_bit   [0:2047];
    bit    exp_first [0:2047];
    string exp_req   [0:2047];
    int wr_i = 0;
    int rd_i = 0;
    int enc_state = 0;
    int blk_pos = 0;
    int unsigned lfsr = 32'h1ace;

    mlvd_core #(.K(K), .BMW(BMW), .PMW(PMW), .L(L), .G0(G0), .G1(G1), .G2(G2)) u_mlvd_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bm(in_bm),
        .out_valid(out_valid), .out_bit(out_bit), .out_first(out_first)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit rnd_bit();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[0];
    endfunction

    // Reference encoder code word (R10).
    function automatic int ref_code(input int st, input bit u);
        int r;
        r = st * 2 + int'(u);
        return ($countones(r & G0) % 2) + 2 * ($countones(r & G1) % 2)
             + 4 * ($countones(r & G2) % 2);
    endfunction

    // Output monitor: every decoded bit and block flag against the queue.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd_i >= wr_i) begin
                check(1'b0, "R7", "output without a step", rd_i, wr_i);
            end else begin
                check(out_bit == exp_bit[rd_i], exp_req[rd_i], "decoded bit",
                      int'(out_bit), int'(exp_bit[rd_i]));
                check(out_first == exp_first[rd_i], "R8", "block start flag",
                      int'(out_first), int'(exp_first[rd_i]));
                rd_i++;
            end
        end
    end

    task automatic push_exp(input bit b, input string req);
        exp_bit[wr_i]   = b;
        exp_first[wr_i] = (blk_pos == 0);
        exp_req[wr_i]   = req;
        wr_i++;
        blk_pos = (blk_pos == L - 1) ? 0 : blk_pos + 1;
    endtask

    task automatic drive(input logic [NBM*BMW-1:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_bm    = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_data(input bit u, input int scale, input string req);
        int tx;
        logic [NBM*BMW-1:0] v;
        tx = ref_code(enc_state, u);
        for (int c = 0; c < NBM; c++)
            v[c*BMW +: BMW] = BMW'(scale * $countones(c ^ tx));
        enc_state = (blk_pos == L - 1) ? 0 : ((enc_state * 2 + int'(u)) % S);
        push_exp(u, req);
        drive(v);
    endtask

    task automatic drain();
        idle(4);
        check(rd_i == wr_i, "R7", "one output per accepted step", rd_i, wr_i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_first == 1'b0, "R1", "out_first in reset", int'(out_first), 0);
        check(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
        rst = 1'b0;
        wr_i = 0; rd_i = 0; enc_state = 0; blk_pos = 0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_latency();
        do_reset();
        send_data(1'b1, 1, "R9");
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R7", "valid after one edge", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7", "valid after two edges", int'(out_valid), 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "single output pulse", int'(out_valid), 0);
        drain();
    endtask

    task automatic t_random_blocks();
        do_reset();
        for (int i = 0; i < 3 * L; i++) send_data(rnd_bit(), 1, "R9 R5 R6 R10");
        drain();
    endtask

    task automatic t_block_edge();
        do_reset();
        for (int i = 0; i < 2 * L; i++) send_data(1'b1, 2, "R4");
        for (int i = 0; i < L; i++) send_data((i % 3) != 0, 2, "R4");
        drain();
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 2 * L; i++) begin
            send_data(rnd_bit(), 1, "R7 R9");
            if (rnd_bit()) idle(1 + int'(rnd_bit()));
        end
        drain();
    endtask

    task automatic t_ties();
        logic [NBM*BMW-1:0] v;
        do_reset();
        for (int c = 0; c < NBM; c++) v[c*BMW +: BMW] = BMW'(9);
        for (int i = 0; i < L + 4; i++) begin
            push_exp(1'b0, "R2");
            drive(v);
        end
        drain();
    endtask

    task automatic t_stress();
        do_reset();
        for (int i = 0; i < 4 * L; i++) send_data((i % 5) < 2, 10, "R3");
        drain();
    endtask

    task automatic t_mid_reset();
        do_reset();
        for (int i = 0; i < 7; i++) send_data(1'b1, 1, "R4");
        drain();
        do_reset();
        for (int i = 0; i < L + 5; i++) send_data((i % 2) == 1, 1, "R4 R1");
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_latency();
        t_random_blocks();
        t_block_edge();
        t_gaps();
        t_ties();
        t_stress();
        t_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule